// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a serial-in, serial-out shift register whose effective length can be set anywhere from 1 to 64 bits. A six-bit length code chooses the length. One of two serial data inputs feeds the register, picked by a select line. Feeding the output back into one of those inputs makes the contents recirculate.

Shifting is triggered by two trigger pins that live outside the system clock domain. Each pin is sampled on the system clock. One pin shifts on its rising edge, but only while the other pin is low. The other pin shifts on its falling edge, but only while the first pin is high.

The block drives a true output and its complement. An asynchronous master reset empties the register. The reset is released in step with the system clock.

Top module: `varlen_shifter`

## Requirements
- R1: The register length is `len_sel + 1`, where `len_sel` is the binary sum of the weights 1, 2, 4, 8, 16 and 32. With `len_sel` = 0, a bit shifted in appears at `dout` after exactly one shift.
- R2: With `len_sel` = 63 the length is 64. A bit reaches `dout` after its 64th shift, and not after its 63rd.
- R3: When `use_a` is 1, the bit shifted in comes from `din_a`. When `use_a` is 0, it comes from `din_b`.
- R4: On a shift, the selected bit enters position 1 and every stored bit moves one position toward the output. Without a shift, the stored contents stay unchanged.
- R5: A rising edge on `trig_r` while `trig_f` is low causes one shift. A rising edge on `trig_r` while `trig_f` is high causes no shift.
- R6: A falling edge on `trig_f` while `trig_r` is high causes one shift. A falling edge on `trig_f` while `trig_r` is low causes no shift.
- R7: While `mrst` is high, every stored bit is cleared, `dout` is 0 and `dout_n` is 1, whatever the other inputs do. This takes effect without waiting for a clock edge.
- R8: No shift takes place at the first clock edge after `mrst` falls, even if a qualifying trigger edge is pending at that edge.
- R9: `dout_n` is always the complement of `dout`.
- R10: `dout` shows the bit at position `len_sel + 1` for the current `len_sel`. A change of `len_sel` moves the tap at once and leaves the stored bits untouched.
- R11: If a qualifying `trig_r` rise and a qualifying `trig_f` fall appear in the same sample, exactly one shift takes place.
- R12: The trigger pins and data inputs are registered on `clk`. The shift for a trigger change that is presented before clock edge k takes place at edge k+1. It uses the data and select values sampled at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| trig_r | input | 1 | Trigger pin that shifts on its rising edge while trig_f is low |
| trig_f | input | 1 | Trigger pin that shifts on its falling edge while trig_r is high |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B |
| use_a | input | 1 | Data select: 1 picks din_a, 0 picks din_b |
| len_sel | input | LW (6) | Length code; length = len_sel + 1 |
| dout | output | 1 | Bit at the programmed tap position |
| dout_n | output | 1 | Complement of dout |

## Verification
Some properties are checked on every cycle. On any effective shift, the first stage takes the sampled input bit. Without a shift, the stage chain holds still. A trigger sample with `trig_f` high never produces a shift. The reset-release edge leaves the register empty.

Other behaviour can only be shown by the bench's scenarios, because it depends on sequences and on the model. These are:
- the exact tap position at both length extremes;
- the source selection;
- the rejection of wrongly gated edges on each pin;
- the single shift when both triggers fire together;
- the immediate tap move when the length code changes;
- the suppression of a trigger edge that lands on the reset-release edge.

// File: rtl/vls_pkg.sv
package vls_pkg;

    // Sampled levels of the two trigger pins.
    typedef struct packed {
        logic rise_pin;
        logic fall_pin;
    } trig_pair_t;

    // Sampled data path inputs.
    typedef struct packed {
        logic a;
        logic b;
        logic use_a;
    } data_sel_t;

    // Bit that the data select routes into the first stage.
    function automatic logic pick_bit(data_sel_t d);
        return d.use_a ? d.a : d.b;
    endfunction

    // A shift is qualified by a rising edge on one pin while the other is low,
    // or by a falling edge on the other pin while the first is high.
    function automatic logic shift_qualified(trig_pair_t now, trig_pair_t prev);
        logic up_ok;
        logic dn_ok;
        up_ok = now.rise_pin & ~prev.rise_pin & ~now.fall_pin;
        dn_ok = ~now.fall_pin & prev.fall_pin & now.rise_pin;
        return up_ok | dn_ok;
    endfunction

endpackage

// File: rtl/vls_sampler.sv
module vls_sampler
    import vls_pkg::*;
(
    input  logic       clk,
    input  logic       mrst,
    input  trig_pair_t pins,
    input  data_sel_t  data,
    output logic       shift,
    output logic       sel_bit
);

    trig_pair_t cur_q;
    trig_pair_t prev_q;
    data_sel_t  data_q;

    // Sampling runs during reset too, so pin history is valid at release.
    always_ff @(posedge clk) begin
        cur_q  <= pins;
        prev_q <= cur_q;
        data_q <= data;
    end

    // Both qualifying edges in one sample still give a single strobe.
    always_comb begin
        shift   = shift_qualified(cur_q, prev_q);
        sel_bit = pick_bit(data_q);
    end

    // A sampled high level on the falling-edge pin blocks every shift.
    assert_fallpin_high_blocks_R5: assert property (@(posedge clk) disable iff (mrst)
        cur_q.fall_pin |-> !shift)
        else $error("shift strobe while fall pin sampled high");

endmodule

// File: rtl/vls_rst_hold.sv
module vls_rst_hold (
    input  logic clk,
    input  logic mrst,
    output logic hold
);

    // Set at once by the master reset, cleared only by a clock edge.
    // The first edge after release therefore still sees hold high.
    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) hold <= 1'b1;
        else      hold <= 1'b0;
    end

endmodule

// File: rtl/vls_chain.sv
module vls_chain #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          hold,
    input  logic          shift,
    input  logic          din,
    input  logic [LW-1:0] len_sel,
    output logic          tap
);

    logic [DEPTH-1:0] store;
    logic [DEPTH-1:0] nxt_vec;
    logic             adv;

    assign adv = shift & ~hold;

    // Index 0 is the first position; each stage takes its lower neighbour.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign nxt_vec[g] = din;
        end else begin : g_body
            assign nxt_vec[g] = store[g-1];
        end
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst)     store <= '0;
        else if (adv) store <= nxt_vec;
    end

    // The tap follows len_sel directly; position len_sel+1 is index len_sel.
    assign tap = store[len_sel];

    assert_head_takes_input_R4: assert property (@(posedge clk) disable iff (mrst)
        adv |=> store[0] == $past(din))
        else $error("first stage missed the input bit");

    assert_idle_keeps_contents_R4: assert property (@(posedge clk) disable iff (mrst)
        !adv |=> $stable(store))
        else $error("contents moved without a shift");

    assert_release_edge_empty_R8: assert property (@(posedge clk) disable iff (mrst)
        hold |=> store == '0)
        else $error("register changed on the reset release edge");

endmodule

// File: rtl/varlen_shifter.sv
module varlen_shifter
    import vls_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          trig_r,
    input  logic          trig_f,
    input  logic          din_a,
    input  logic          din_b,
    input  logic          use_a,
    input  logic [LW-1:0] len_sel,
    output logic          dout,
    output logic          dout_n
);

    trig_pair_t pins;
    data_sel_t  data;
    logic       shift;
    logic       sel_bit;
    logic       hold;
    logic       tap;

    assign pins = '{rise_pin: trig_r, fall_pin: trig_f};
    assign data = '{a: din_a, b: din_b, use_a: use_a};

    vls_sampler u_sampler (
        .clk     (clk),
        .mrst    (mrst),
        .pins    (pins),
        .data    (data),
        .shift   (shift),
        .sel_bit (sel_bit)
    );

    vls_rst_hold u_hold (
        .clk  (clk),
        .mrst (mrst),
        .hold (hold)
    );

    vls_chain #(.DEPTH(DEPTH)) u_chain (
        .clk     (clk),
        .mrst    (mrst),
        .hold    (hold),
        .shift   (shift),
        .din     (sel_bit),
        .len_sel (len_sel),
        .tap     (tap)
    );

    // The master reset also forces the outputs directly.
    assign dout   = tap & ~mrst;
    assign dout_n = ~dout;

endmodule

// File: tb/varlen_shifter_tb.sv
module varlen_shifter_tb;

    logic       clk = 1'b0;
    logic       mrst;
    logic       trig_r;
    logic       trig_f;
    logic       din_a;
    logic       din_b;
    logic       use_a;
    logic [5:0] len_sel;
    logic       dout;
    logic       dout_n;

    int         checks = 0;
    int         errors = 0;
    logic [63:0] model;

    always #5 clk = ~clk;

    varlen_shifter u_dut (
        .clk(clk), .mrst(mrst), .trig_r(trig_r), .trig_f(trig_f),
        .din_a(din_a), .din_b(din_b), .use_a(use_a), .len_sel(len_sel),
        .dout(dout), .dout_n(dout_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(req, dout, model[len_sel]);
        check({req, "/R9"}, dout_n, ~model[len_sel]);
    endtask

    task automatic set_data(input logic bitv, input logic sel_a);
        use_a = sel_a;
        din_a = sel_a ? bitv : ~bitv;
        din_b = sel_a ? ~bitv : bitv;
    endtask

    // R5/R12: trig_r rise with trig_f low; shift lands by the second edge.
    task automatic push(input logic bitv, input logic sel_a);
        @(negedge clk);
        set_data(bitv, sel_a);
        trig_r = 1'b1;
        repeat (2) @(negedge clk);
        trig_r = 1'b0;
        @(negedge clk);
        model = {model[62:0], bitv};
    endtask

    task automatic do_reset();
        @(negedge clk);
        mrst = 1'b1;
        repeat (2) @(negedge clk);
        mrst = 1'b0;
        repeat (2) @(negedge clk);
        model = '0;
    endtask

    task automatic t_reset_state();
        len_sel = 6'd0;
        do_reset();
        for (int i = 0; i < 64; i++) begin
            len_sel = i[5:0];
            #1;
            check("R7 reset state", dout, 1'b0);
        end
        check("R9 reset complement", dout_n, 1'b1);
    endtask

    task automatic t_len_one();
        len_sel = 6'd0;
        push(1'b1, 1'b1);
        check_out("R1 len1 one");
        check("R1 len1 value", dout, 1'b1);
        push(1'b0, 1'b1);
        check("R1 len1 zero", dout, 1'b0);
    endtask

    task automatic t_len_max();
        do_reset();
        len_sel = 6'd63;
        push(1'b1, 1'b0);
        for (int i = 0; i < 62; i++) push(1'b0, 1'b0);
        check("R2 after 63 shifts", dout, 1'b0);
        push(1'b0, 1'b0);
        check("R2 after 64 shifts", dout, 1'b1);
        check_out("R2 model");
    endtask

    task automatic t_select();
        len_sel = 6'd0;
        push(1'b1, 1'b1);
        check("R3 use A", dout, 1'b1);
        push(1'b0, 1'b1);
        check("R3 use A zero", dout, 1'b0);
        push(1'b1, 1'b0);
        check("R3 use B", dout, 1'b1);
        push(1'b0, 1'b0);
        check("R3 use B zero", dout, 1'b0);
    endtask

    task automatic t_blocked_rise();
        len_sel = 6'd0;
        push(1'b0, 1'b1);
        @(negedge clk);
        trig_f = 1'b1;
        repeat (2) @(negedge clk);
        set_data(1'b1, 1'b1);
        trig_r = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 rise with fall pin high", dout, 1'b0);
        // trig_f now falls while trig_r is high: one shift (R6)
        trig_f = 1'b0;
        repeat (3) @(negedge clk);
        model = {model[62:0], 1'b1};
        check("R6 fall with rise pin high", dout, 1'b1);
        trig_r = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 no shift on rise pin fall", dout, 1'b1);
    endtask

    task automatic t_blocked_fall();
        len_sel = 6'd0;
        set_data(1'b0, 1'b0);
        trig_f = 1'b1;
        repeat (2) @(negedge clk);
        trig_f = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 fall with rise pin low", dout, 1'b1);
    endtask

    task automatic t_len_change();
        len_sel = 6'd7;
        push(1'b1, 1'b1); push(1'b0, 1'b1); push(1'b1, 1'b1); push(1'b1, 1'b1);
        push(1'b0, 1'b1); push(1'b0, 1'b1); push(1'b1, 1'b1); push(1'b0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            len_sel = i[5:0];
            #1;
            check_out("R10 tap move");
        end
        len_sel = 6'd7;
        #1;
        check_out("R10 contents kept");
    endtask

    task automatic t_both_edges();
        len_sel = 6'd1;
        @(negedge clk);
        trig_f = 1'b1;
        repeat (2) @(negedge clk);
        set_data(1'b0, 1'b1);
        trig_r = 1'b1;
        trig_f = 1'b0;
        repeat (3) @(negedge clk);
        model = {model[62:0], 1'b0};
        len_sel = 6'd1;
        #1;
        check_out("R11 single shift pos2");
        len_sel = 6'd2;
        #1;
        check_out("R11 single shift pos3");
        trig_r = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_async_reset();
        len_sel = 6'd0;
        push(1'b1, 1'b1);
        @(negedge clk);
        #1 mrst = 1'b1;
        #1;
        check("R7 immediate clear", dout, 1'b0);
        check("R7 immediate complement", dout_n, 1'b1);
        set_data(1'b1, 1'b1);
        trig_r = 1'b1;
        @(negedge clk);
        check("R7 trigger ignored in reset", dout, 1'b0);
        mrst = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 no shift at release", dout, 1'b0);
        trig_r = 1'b0;
        @(negedge clk);
        model = '0;
        for (int i = 0; i < 64; i++) begin
            len_sel = i[5:0];
            #1;
            check_out("R8 register empty");
        end
    endtask

    initial begin
        mrst = 1'b1; trig_r = 1'b0; trig_f = 1'b0;
        din_a = 1'b0; din_b = 1'b0; use_a = 1'b0; len_sel = '0;
        model = '0;
        t_reset_state();
        t_len_one();
        t_len_max();
        t_select();
        t_blocked_rise();
        t_blocked_fall();
        t_len_change();
        t_both_edges();
        t_async_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule